// File: doc/BRIEF.md
# Threshold Alarm Latch

This block watches two usage counters, a wide elapsed-time count and a narrower event count. Each counter is compared with a programmable limit of its own width. The result of each comparison appears as a live status flag, and the flag clears by itself once the count falls back under its limit. A limit of zero switches its comparison off.

The flags feed a sticky alarm. For each source, an enable bit decides whether its flag may arm the alarm. Once set, the alarm holds until software issues a one-cycle clear pulse. The alarm appears at the edge as an output-enable and a drive level, which together suit an open-drain pad. A polarity bit chooses the level driven while the alarm is active. While the alarm is inactive, the pad is released (high impedance).

Control is a two-state machine:
- `ALM_IDLE`: the alarm is not active.
- `ALM_LATCHED`: the alarm is active.

Its transitions are:
- ARM: `ALM_IDLE` to `ALM_LATCHED`, taken when an enabled flag is set and no clear is present.
- HOLD: `ALM_LATCHED` stays in `ALM_LATCHED` while no clear is present, whatever the flags do.
- RELEASE: `ALM_LATCHED` to `ALM_IDLE` on a clear pulse.
- BLOCK: `ALM_IDLE` stays in `ALM_IDLE` in a cycle that carries a clear pulse, even when the alarm is armed.

Top module: `alarm_thr_top`

## Requirements
- R1: `status_flags[0]` is the time flag. One clock edge after the inputs change, it equals 1 exactly when `time_limit` is nonzero and `time_count` >= `time_limit`. It returns to 0 by itself when the count drops below the limit.
- R2: `status_flags[1]` is the event flag. It follows the same rule as R1, applied to `event_count` and `event_limit`.
- R3: When a limit is all zeros, its flag stays 0 for every count value.
- R4: A set flag arms the alarm when its enable bit is 1. The enable for the time flag is `cfg_bits[2]` and the enable for the event flag is `cfg_bits[1]`. The alarm becomes active on the clock edge after the flag is set, which is two edges after the count change.
- R5: A flag whose enable bit is 0 never activates the alarm.
- R6: Once active, the alarm stays active after every flag has cleared, until a clear pulse arrives.
- R7: A cycle with `clr_pulse` = 1 makes the alarm inactive on that clock edge, even if the alarm is armed in the same cycle. If an enabled condition still holds, the alarm becomes active again on the next edge.
- R8: While the alarm is active, `pin_oe` = 1 and `pin_level` = `cfg_bits[0]`. A value of 0 means active-low and 1 means active-high. While the alarm is inactive, `pin_oe` = 0 and `pin_level` = 0.
- R9: While `rst_n` is low, `status_flags`, `pin_oe` and `pin_level` are all 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_count | input | TIME_W | Elapsed-time count |
| event_count | input | EVT_W | Event count |
| time_limit | input | TIME_W | Time alarm limit, zero disables the comparison |
| event_limit | input | EVT_W | Event alarm limit, zero disables the comparison |
| cfg_bits | input | 3 | Bit 2: time enable; bit 1: event enable; bit 0: polarity |
| clr_pulse | input | 1 | Single-cycle alarm release |
| status_flags | output | 2 | Bit 0: time flag; bit 1: event flag |
| pin_oe | output | 1 | Pad output-enable, 1 while the alarm is active |
| pin_level | output | 1 | Level driven while `pin_oe` is 1 |

## Verification
The embedded assertions check the following on every cycle:
- Each registered flag follows its comparison, and a zero limit keeps the flag low.
- A clear always wins over an arm in the same cycle.
- The latch only sets when armed and only releases on a clear.
- The pad never carries a level while it is released.

Other behaviour shows only in the bench's scenarios:
- The exhaustive sweep of counts against limits, run on narrow widths.
- The relation between each enable bit and its own source.
- The polarity seen at the pad.
- The sticky hold after the counts fall.
- Reassertion one edge after a clear while the condition persists.

// File: rtl/alarm_thr_pkg.sv
package alarm_thr_pkg;

    // Alarm latch states
    typedef enum logic [0:0] {
        ALM_IDLE    = 1'b0,
        ALM_LATCHED = 1'b1
    } alm_state_e;

    // Configuration bit positions
    localparam int CFG_W           = 3;
    localparam int CFG_POL_BIT     = 0;
    localparam int CFG_EVT_EN_BIT  = 1;
    localparam int CFG_TIME_EN_BIT = 2;

    // Status flag positions
    localparam int NUM_SRC       = 2;
    localparam int FLAG_TIME_BIT = 0;
    localparam int FLAG_EVT_BIT  = 1;

endpackage

// File: rtl/alarm_thr_cmp.sv
module alarm_thr_cmp #(
    parameter int W         = 32,
    parameter bit REG_FLAG  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count,
    input  logic [W-1:0] limit,
    output logic         flag
);

    localparam logic [W-1:0] ZERO_LIMIT = '0;

    logic limit_live;
    logic hit;

    // A zero limit switches the comparison off.
    assign limit_live = (limit != ZERO_LIMIT);
    assign hit        = limit_live && (count >= limit);

    generate
        if (REG_FLAG) begin : g_reg
            logic flag_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flag_q <= 1'b0;
                else        flag_q <= hit;
            end

            assign flag = flag_q;

            AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                (limit != ZERO_LIMIT && count >= limit) |=> flag);   // R1
            AST_FLAG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                (count < limit) |=> !flag);                          // R1
            AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                (limit == ZERO_LIMIT) |=> !flag);                    // R3
        end else begin : g_comb
            assign flag = hit;
        end
    endgenerate

endmodule

// File: rtl/alarm_thr_fsm.sv
module alarm_thr_fsm
    import alarm_thr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clr,
    output logic latched
);

    alm_state_e state_q;
    alm_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_IDLE: begin
                // ARM, unless a clear in the same cycle blocks it
                if (arm && !clr) state_d = ALM_LATCHED;
            end
            ALM_LATCHED: begin
                // RELEASE on clear, otherwise HOLD
                if (clr) state_d = ALM_IDLE;
            end
            default: state_d = ALM_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALM_IDLE;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ALM_LATCHED: latched = 1'b1;
            default:     latched = 1'b0;
        endcase
    end

    AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !clr) |=> latched);                 // R4
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched && !arm) |=> !latched);           // R5
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !clr) |=> latched);             // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !latched);                          // R7

endmodule

// File: rtl/alarm_thr_pin.sv
module alarm_thr_pin (
    input  logic active,
    input  logic polarity,
    output logic pin_oe,
    output logic pin_level
);

    always_comb begin
        pin_oe    = active;
        pin_level = active & polarity;
    end

    always_comb begin
        AST_NO_LEVEL_WHEN_RELEASED: assert (pin_oe || !pin_level);  // R8
    end

endmodule

// File: rtl/alarm_thr_top.sv
module alarm_thr_top
    import alarm_thr_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int EVT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_count,
    input  logic [EVT_W-1:0]  event_count,
    input  logic [TIME_W-1:0] time_limit,
    input  logic [EVT_W-1:0]  event_limit,
    input  logic [CFG_W-1:0]  cfg_bits,
    input  logic              clr_pulse,
    output logic [NUM_SRC-1:0] status_flags,
    output logic              pin_oe,
    output logic              pin_level
);

    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] enables;
    logic               arm_any;
    logic               latched;

    alarm_thr_cmp #(.W(TIME_W), .REG_FLAG(1'b1)) u_time_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .count (time_count),
        .limit (time_limit),
        .flag  (flags[FLAG_TIME_BIT])
    );

    alarm_thr_cmp #(.W(EVT_W), .REG_FLAG(1'b1)) u_evt_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .count (event_count),
        .limit (event_limit),
        .flag  (flags[FLAG_EVT_BIT])
    );

    // Each flag is gated by its own enable before it can arm the alarm.
    assign enables[FLAG_TIME_BIT] = cfg_bits[CFG_TIME_EN_BIT];
    assign enables[FLAG_EVT_BIT]  = cfg_bits[CFG_EVT_EN_BIT];
    assign arm_any                = |(flags & enables);

    alarm_thr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm_any),
        .clr     (clr_pulse),
        .latched (latched)
    );

    alarm_thr_pin u_pin (
        .active    (latched),
        .polarity  (cfg_bits[CFG_POL_BIT]),
        .pin_oe    (pin_oe),
        .pin_level (pin_level)
    );

    assign status_flags = flags;

    AST_OE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe) |-> $past(arm_any));          // R4

endmodule

// File: tb/alarm_thr_top_bench.sv
`timescale 1ns/1ps
module alarm_thr_top_bench;

    localparam int TW = 4;
    localparam int EW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] time_count = '0;
    logic [EW-1:0] event_count = '0;
    logic [TW-1:0] time_limit = '0;
    logic [EW-1:0] event_limit = '0;
    logic [2:0]    cfg_bits = '0;
    logic          clr_pulse = 1'b0;
    logic [1:0]    status_flags;
    logic          pin_oe;
    logic          pin_level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alarm_thr_top #(.TIME_W(TW), .EVT_W(EW)) u_alarm_thr_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .time_count   (time_count),
        .event_count  (event_count),
        .time_limit   (time_limit),
        .event_limit  (event_limit),
        .cfg_bits     (cfg_bits),
        .clr_pulse    (clr_pulse),
        .status_flags (status_flags),
        .pin_oe       (pin_oe),
        .pin_level    (pin_level)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        clr_pulse = 1'b1;
        tick();
        clr_pulse = 1'b0;
    endtask

    initial begin
        // R9: outputs stay quiet while reset is held, even with conditions true.
        time_count  = 4'd9;
        time_limit  = 4'd2;
        event_count = 3'd5;
        event_limit = 3'd1;
        cfg_bits    = 3'b111;
        repeat (4) tick();
        chk("R9 flags", int'(status_flags), 0);
        chk("R9 oe", int'(pin_oe), 0);
        chk("R9 level", int'(pin_level), 0);

        time_limit  = '0;
        event_limit = '0;
        cfg_bits    = 3'b000;
        rst_n       = 1'b1;
        tick();
        chk("R9 flags after release", int'(status_flags), 0);
        chk("R9 oe after release", int'(pin_oe), 0);

        // R1/R3: exhaustive sweep of time count against time limit.
        for (int l = 0; l < 16; l++) begin
            for (int t = 0; t < 16; t++) begin
                time_limit = l[TW-1:0];
                time_count = t[TW-1:0];
                tick();
                if (l == 0) chk("R3 time zero limit", int'(status_flags[0]), 0);
                else        chk("R1 time flag", int'(status_flags[0]), (t >= l) ? 1 : 0);
            end
        end
        time_limit = '0;

        // R2/R3: exhaustive sweep of event count against event limit.
        for (int l = 0; l < 8; l++) begin
            for (int e = 0; e < 8; e++) begin
                event_limit = l[EW-1:0];
                event_count = e[EW-1:0];
                tick();
                if (l == 0) chk("R3 event zero limit", int'(status_flags[1]), 0);
                else        chk("R2 event flag", int'(status_flags[1]), (e >= l) ? 1 : 0);
            end
        end
        event_limit = '0;
        tick();
        chk("R1 R2 flags idle", int'(status_flags), 0);

        // R4 R5 R6 R7 R8: every configuration against every condition pattern.
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 4; p++) begin
                int tc   = p & 1;
                int ec   = (p >> 1) & 1;
                int pol  = c & 1;
                int e_en = (c >> 1) & 1;
                int t_en = (c >> 2) & 1;
                int act  = (tc & t_en) | (ec & e_en);

                cfg_bits    = c[2:0];
                time_limit  = 4'd3;
                event_limit = 3'd2;
                time_count  = (tc != 0) ? 4'd5 : 4'd1;
                event_count = (ec != 0) ? 3'd4 : 3'd1;
                tick();
                chk("R4 not yet active", int'(pin_oe), 0);
                tick();
                chk(act != 0 ? "R4 alarm active" : "R5 alarm blocked", int'(pin_oe), act);
                chk("R8 level", int'(pin_level), act & pol);

                // Counts fall back: flags drop, alarm stays.
                time_count  = 4'd0;
                event_count = 3'd0;
                repeat (3) tick();
                chk("R1 R2 flags cleared", int'(status_flags), 0);
                chk("R6 sticky", int'(pin_oe), act);

                pulse_clear();
                chk("R7 released", int'(pin_oe), 0);
                chk("R8 level released", int'(pin_level), 0);
            end
        end

        // R7: clear while the condition persists; clear wins, then reassert.
        cfg_bits    = 3'b101;
        time_limit  = 4'd4;
        time_count  = 4'd7;
        event_limit = '0;
        repeat (2) tick();
        chk("R4 active high setup", int'(pin_oe), 1);
        chk("R8 active high level", int'(pin_level), 1);
        pulse_clear();
        chk("R7 clear wins", int'(pin_oe), 0);
        tick();
        chk("R7 reassert", int'(pin_oe), 1);
        chk("R8 reassert level", int'(pin_level), 1);

        // R5: the event enable does not arm from the time flag.
        pulse_clear();
        cfg_bits = 3'b010;
        tick();
        pulse_clear();
        repeat (3) tick();
        chk("R5 wrong enable", int'(pin_oe), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule